// File: doc/BRIEF.md
# Integer Execute Stage with Register File

This block carries out one 32-bit RISC register-register or register-immediate instruction per clock. It holds a thirty-two entry, 32-bit register bank with two combinational read ports and one write port that updates on the rising clock edge. The instruction word is split into its fields. The decoder then picks an arithmetic, logic, compare or shift operation. The second operand is either a register or an immediate, and the immediate is extended in one of three ways: sign-extended, zero-extended, or placed in the upper half.

The write-back index, data and enable are visible at the ports in the same cycle as the instruction. The register bank takes the result at the next rising edge. For loads and stores the block computes the memory address. It does not touch memory: load data comes back outside this block, so a load does not raise the write enable here. An opcode or function code that the block does not know raises an illegal flag and blocks the write.

Top module: `int_exec_core`

## Requirements
- R1: A synchronous active-high reset clears all thirty-two registers to zero.
- R2: Register 0 always reads as zero. A write aimed at index 0 may show wb_en high, but it leaves register 0 at zero.
- R3: With op field [31:26] = 0, funct [5:0] 0x20 adds and 0x22 subtracts (rs minus rt). The sum or difference wraps modulo 2^32, and the destination is rd [15:11].
- R4: With op = 0, funct 0x24 gives AND, 0x25 gives OR and 0x27 gives NOR of rs [25:21] and rt [20:16]. The destination is rd.
- R5: funct 0x2A (op 0) and opcode 0x0A both write 1 when rs is less than the second operand in a signed comparison, and 0 otherwise.
- R6: With op = 0, funct 0x00 shifts rt left, 0x02 shifts rt right with zero fill and 0x03 shifts rt right with sign fill. The shift amount is shamt [10:6], and the destination is rd.
- R7: Opcodes 0x08 (add) and 0x0A (compare) use imm [15:0] sign-extended to 32 bits. The destination is rt [20:16].
- R8: Opcodes 0x0C (AND) and 0x0D (OR) use imm [15:0] zero-extended. The destination is rt.
- R9: Opcode 0x0F writes imm [15:0] into bits [31:16] of rt and clears bits [15:0].
- R10: For opcodes 0x23 (load) and 0x2B (store), eff_addr equals rs plus the sign-extended imm, wrapping modulo 2^32. The load shows rt on wb_idx. Neither opcode asserts wb_en.
- R11: Any other opcode, or op 0 with a funct outside the set listed above, raises illegal while instr_valid is high. wb_en stays low and no register changes.
- R12: While instr_valid is low, wb_en and illegal both stay low and no register changes.
- R13: A result written in one cycle is the value the operand read returns in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction word is valid this cycle |
| instr_word | input | 32 | Instruction to execute |
| wb_en | output | 1 | Result is written at the next rising edge |
| wb_idx | output | 5 | Destination register index |
| wb_data | output | 32 | Result value |
| eff_addr | output | 32 | rs plus sign-extended immediate |
| illegal | output | 1 | Unknown opcode or function code |

## Verification
The properties assume that instr_word is stable between clock edges and only has meaning while instr_valid is high. Outside that window they only check that wb_en and illegal stay quiet. The bench changes inputs only at falling edges and samples one nanosecond later. Each instruction is therefore seen whole for the full evaluation window, and each write lands at the rising edge that follows. The bench reads register contents back only through OR instructions with register 0, so every stored value is observed at the ports.

// File: rtl/int_exec_pkg.sv
package int_exec_pkg;

    localparam int XLEN      = 32;
    localparam int REG_COUNT = 32;
    localparam int IDX_W     = $clog2(REG_COUNT);
    localparam int IMM_W     = 16;

    localparam logic [5:0] OPC_RTYPE = 6'h00;
    localparam logic [5:0] OPC_ADDI  = 6'h08;
    localparam logic [5:0] OPC_SLTI  = 6'h0A;
    localparam logic [5:0] OPC_ANDI  = 6'h0C;
    localparam logic [5:0] OPC_ORI   = 6'h0D;
    localparam logic [5:0] OPC_LUI   = 6'h0F;
    localparam logic [5:0] OPC_LOAD  = 6'h23;
    localparam logic [5:0] OPC_STORE = 6'h2B;

    localparam logic [5:0] FN_SLL = 6'h00;
    localparam logic [5:0] FN_SRL = 6'h02;
    localparam logic [5:0] FN_SRA = 6'h03;
    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;
    localparam logic [5:0] FN_AND = 6'h24;
    localparam logic [5:0] FN_OR  = 6'h25;
    localparam logic [5:0] FN_NOR = 6'h27;
    localparam logic [5:0] FN_SLT = 6'h2A;

    typedef enum logic [3:0] {
        ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_NOR,
        ALU_SLT, ALU_SLL, ALU_SRL, ALU_SRA, ALU_PASSB
    } alu_op_e;

    typedef enum logic [1:0] {
        IMM_SIGNED, IMM_ZERO, IMM_UPPER
    } imm_kind_e;

    typedef struct packed {
        alu_op_e          op;
        logic             use_imm;
        imm_kind_e        imm_kind;
        logic [IDX_W-1:0] dest;
        logic             writes;
        logic             legal;
    } decode_t;

    function automatic logic [XLEN-1:0] widen_imm(input logic [IMM_W-1:0] imm,
                                                  input imm_kind_e kind);
        logic [XLEN-1:0] r;
        case (kind)
            IMM_ZERO:  r = {{(XLEN-IMM_W){1'b0}}, imm};
            IMM_UPPER: r = {imm, {(XLEN-IMM_W){1'b0}}};
            default:   r = {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};
        endcase
        return r;
    endfunction

endpackage

// File: rtl/int_exec_regbank.sv
module int_exec_regbank #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 32,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr_a,
    input  logic [AW-1:0]    raddr_b,
    output logic [WIDTH-1:0] rdata_a,
    output logic [WIDTH-1:0] rdata_b
);
    logic [WIDTH-1:0] entry [DEPTH];

    // Entry zero is a hard-wired constant.
    assign entry[0] = '0;

    for (genvar g = 1; g < DEPTH; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst)
                entry[g] <= '0;
            else if (we && waddr == AW'(g))
                entry[g] <= wdata;
        end
    end

    assign rdata_a = entry[raddr_a];
    assign rdata_b = entry[raddr_b];
endmodule

// File: rtl/int_exec_decode.sv
module int_exec_decode
    import int_exec_pkg::*;
(
    input  logic [XLEN-1:0] instr,
    output decode_t         dec
);
    logic [5:0]       opc;
    logic [5:0]       fn;
    logic [IDX_W-1:0] f_rt;
    logic [IDX_W-1:0] f_rd;

    assign opc  = instr[31:26];
    assign fn   = instr[5:0];
    assign f_rt = instr[20:16];
    assign f_rd = instr[15:11];

    always_comb begin
        dec          = '0;
        dec.op       = ALU_ADD;
        dec.imm_kind = IMM_SIGNED;
        dec.dest     = f_rt;
        dec.use_imm  = 1'b1;
        dec.writes   = 1'b1;
        dec.legal    = 1'b1;
        case (opc)
            OPC_RTYPE: begin
                dec.use_imm = 1'b0;
                dec.dest    = f_rd;
                case (fn)
                    FN_ADD:  dec.op = ALU_ADD;
                    FN_SUB:  dec.op = ALU_SUB;
                    FN_AND:  dec.op = ALU_AND;
                    FN_OR:   dec.op = ALU_OR;
                    FN_NOR:  dec.op = ALU_NOR;
                    FN_SLT:  dec.op = ALU_SLT;
                    FN_SLL:  dec.op = ALU_SLL;
                    FN_SRL:  dec.op = ALU_SRL;
                    FN_SRA:  dec.op = ALU_SRA;
                    default: begin
                        dec.legal  = 1'b0;
                        dec.writes = 1'b0;
                    end
                endcase
            end
            OPC_ADDI: dec.op = ALU_ADD;
            OPC_SLTI: dec.op = ALU_SLT;
            OPC_ANDI: begin
                dec.op       = ALU_AND;
                dec.imm_kind = IMM_ZERO;
            end
            OPC_ORI: begin
                dec.op       = ALU_OR;
                dec.imm_kind = IMM_ZERO;
            end
            OPC_LUI: begin
                dec.op       = ALU_PASSB;
                dec.imm_kind = IMM_UPPER;
            end
            OPC_LOAD, OPC_STORE: dec.writes = 1'b0;
            default: begin
                dec.legal  = 1'b0;
                dec.writes = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/int_exec_alu.sv
module int_exec_alu
    import int_exec_pkg::*;
(
    input  alu_op_e         op,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    input  logic [4:0]      shamt,
    output logic [XLEN-1:0] y
);
    always_comb begin
        case (op)
            ALU_ADD:   y = a + b;
            ALU_SUB:   y = a - b;
            ALU_AND:   y = a & b;
            ALU_OR:    y = a | b;
            ALU_NOR:   y = ~(a | b);
            ALU_SLT:   y = {{(XLEN-1){1'b0}}, ($signed(a) < $signed(b))};
            ALU_SLL:   y = b << shamt;
            ALU_SRL:   y = b >> shamt;
            ALU_SRA:   y = $unsigned($signed(b) >>> shamt);
            default:   y = b;
        endcase
    end
endmodule

// File: rtl/int_exec_core.sv
module int_exec_core
    import int_exec_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        instr_valid,
    input  logic [31:0] instr_word,
    output logic        wb_en,
    output logic [4:0]  wb_idx,
    output logic [31:0] wb_data,
    output logic [31:0] eff_addr,
    output logic        illegal
);
    decode_t         dec;
    logic [XLEN-1:0] src_a;
    logic [XLEN-1:0] src_b;
    logic [XLEN-1:0] imm_val;
    logic [XLEN-1:0] opnd_b;
    logic [XLEN-1:0] result;

    int_exec_decode u_decode (
        .instr (instr_word),
        .dec   (dec)
    );

    int_exec_regbank #(.WIDTH(XLEN), .DEPTH(REG_COUNT)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .we      (wb_en),
        .waddr   (dec.dest),
        .wdata   (result),
        .raddr_a (instr_word[25:21]),
        .raddr_b (instr_word[20:16]),
        .rdata_a (src_a),
        .rdata_b (src_b)
    );

    assign imm_val = widen_imm(instr_word[15:0], dec.imm_kind);
    assign opnd_b  = dec.use_imm ? imm_val : src_b;

    int_exec_alu u_alu (
        .op    (dec.op),
        .a     (src_a),
        .b     (opnd_b),
        .shamt (instr_word[10:6]),
        .y     (result)
    );

    assign wb_en    = instr_valid & dec.writes & dec.legal;
    assign illegal  = instr_valid & ~dec.legal;
    assign wb_idx   = dec.dest;
    assign wb_data  = result;
    assign eff_addr = src_a + widen_imm(instr_word[15:0], IMM_SIGNED);
endmodule

// File: rtl/int_exec_chk.sv
module int_exec_chk (
    input logic        clk,
    input logic        rst,
    input logic        instr_valid,
    input logic [31:0] instr_word,
    input logic        wb_en,
    input logic [4:0]  wb_idx,
    input logic [31:0] wb_data,
    input logic        illegal
);
    // R11
    illegal_blocks_wb_chk: assert property (@(posedge clk) disable iff (rst)
        illegal |-> !wb_en);

    // R12
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !instr_valid |-> (!wb_en && !illegal));

    // R10
    mem_no_wb_chk: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && (instr_word[31:26] == 6'h23 || instr_word[31:26] == 6'h2B))
        |-> (!wb_en && !illegal));

    // R9
    upper_low_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (wb_en && instr_word[31:26] == 6'h0F) |-> (wb_data[15:0] == 16'h0));

    // R5
    compare_bool_chk: assert property (@(posedge clk) disable iff (rst)
        (wb_en && (instr_word[31:26] == 6'h0A ||
                   (instr_word[31:26] == 6'h00 && instr_word[5:0] == 6'h2A)))
        |-> (wb_data[31:1] == 31'h0));

    // R3
    rtype_dest_chk: assert property (@(posedge clk) disable iff (rst)
        (wb_en && instr_word[31:26] == 6'h00) |-> (wb_idx == instr_word[15:11]));

    // R7
    itype_dest_chk: assert property (@(posedge clk) disable iff (rst)
        (wb_en && instr_word[31:26] != 6'h00) |-> (wb_idx == instr_word[20:16]));
endmodule

bind int_exec_core int_exec_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .instr_valid (instr_valid),
    .instr_word  (instr_word),
    .wb_en       (wb_en),
    .wb_idx      (wb_idx),
    .wb_data     (wb_data),
    .illegal     (illegal)
);

// File: tb/int_exec_core_tb_top.sv
`timescale 1ns/1ps
module int_exec_core_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        instr_valid = 1'b0;
    logic [31:0] instr_word = '0;
    logic        wb_en;
    logic [4:0]  wb_idx;
    logic [31:0] wb_data;
    logic [31:0] eff_addr;
    logic        illegal;

    int n_cmp = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    int_exec_core dut_i (
        .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr_word(instr_word),
        .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data),
        .eff_addr(eff_addr), .illegal(illegal)
    );

    function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd,
                                          input int sh, input int fn);
        return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'(sh), 6'(fn)};
    endfunction

    function automatic logic [31:0] enc_i(input int op, input int rs, input int rt,
                                          input int imm);
        return {6'(op), 5'(rs), 5'(rt), 16'(imm)};
    endfunction

    // {instruction, expected wb_en, expected wb_idx, expected wb_data}
    localparam int NV = 24;
    localparam logic [69:0] VEC [NV] = '{
        {enc_i(8'h0D, 0, 1, 16'h1234),  1'b1, 5'd1,  32'h0000_1234}, // R8 ori
        {enc_i(8'h0F, 0, 2, 16'h8000),  1'b1, 5'd2,  32'h8000_0000}, // R9 lui
        {enc_i(8'h08, 0, 3, 16'hFFFF),  1'b1, 5'd3,  32'hFFFF_FFFF}, // R7 addi -1
        {enc_i(8'h0D, 0, 4, 16'hFFFF),  1'b1, 5'd4,  32'h0000_FFFF}, // R8 zero-ext
        {enc_i(8'h0C, 3, 5, 16'h8001),  1'b1, 5'd5,  32'h0000_8001}, // R8 andi
        {enc_r(3, 1, 6, 0, 8'h20),      1'b1, 5'd6,  32'h0000_1233}, // R3 add wraps
        {enc_r(0, 1, 7, 0, 8'h22),      1'b1, 5'd7,  32'hFFFF_EDCC}, // R3 sub
        {enc_r(3, 1, 8, 0, 8'h24),      1'b1, 5'd8,  32'h0000_1234}, // R4 and
        {enc_r(2, 1, 9, 0, 8'h25),      1'b1, 5'd9,  32'h8000_1234}, // R4 or
        {enc_r(1, 0, 10, 0, 8'h27),     1'b1, 5'd10, 32'hFFFF_EDCB}, // R4 nor
        {enc_r(2, 1, 11, 0, 8'h2A),     1'b1, 5'd11, 32'h0000_0001}, // R5 slt true
        {enc_r(1, 2, 12, 0, 8'h2A),     1'b1, 5'd12, 32'h0000_0000}, // R5 slt false
        {enc_i(8'h0A, 3, 13, 16'h0000), 1'b1, 5'd13, 32'h0000_0001}, // R5 slti
        {enc_i(8'h0A, 1, 14, 16'h8000), 1'b1, 5'd14, 32'h0000_0000}, // R5 R7 neg imm
        {enc_r(0, 1, 15, 4, 8'h00),     1'b1, 5'd15, 32'h0001_2340}, // R6 sll
        {enc_r(0, 2, 16, 31, 8'h02),    1'b1, 5'd16, 32'h0000_0001}, // R6 srl
        {enc_r(0, 2, 17, 4, 8'h03),     1'b1, 5'd17, 32'hF800_0000}, // R6 sra neg
        {enc_r(0, 1, 18, 4, 8'h03),     1'b1, 5'd18, 32'h0000_0123}, // R6 sra pos
        {enc_r(1, 1, 0, 0, 8'h20),      1'b1, 5'd0,  32'h0000_2468}, // R2 write r0
        {enc_r(0, 0, 19, 0, 8'h25),     1'b1, 5'd19, 32'h0000_0000}, // R2 r0 reads 0
        {enc_i(8'h08, 2, 20, 16'h7FFF), 1'b1, 5'd20, 32'h8000_7FFF}, // R7 addi
        {enc_r(2, 2, 21, 0, 8'h20),     1'b1, 5'd21, 32'h0000_0000}, // R3 wrap to 0
        {enc_i(8'h08, 1, 1, 16'h0001),  1'b1, 5'd1,  32'h0000_1235}, // R13 update
        {enc_r(1, 0, 22, 0, 8'h25),     1'b1, 5'd22, 32'h0000_1235}  // R13 sees it
    };

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic issue(input logic [31:0] w, input logic v);
        @(negedge clk);
        instr_word  = w;
        instr_valid = v;
        #1;
    endtask

    task automatic read_reg(input int r, input string req, input logic [31:0] exp);
        issue(enc_r(r, 0, 31, 0, 8'h25), 1'b1);
        check(req, "readback", wb_data, exp);
    endtask

    initial begin
        #(8 * 100000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R12 idle outputs after reset
        check("R12", "wb_en idle", 32'(wb_en), 32'h0);
        check("R12", "illegal idle", 32'(illegal), 32'h0);
        // R1 registers cleared
        read_reg(3, "R1", 32'h0);

        for (int i = 0; i < NV; i++) begin
            issue(VEC[i][69:38], 1'b1);
            check("vec", $sformatf("wb_en #%0d", i), 32'(wb_en), 32'(VEC[i][37]));
            check("vec", $sformatf("wb_idx #%0d", i), 32'(wb_idx), 32'(VEC[i][36:32]));
            check("vec", $sformatf("wb_data #%0d", i), wb_data, VEC[i][31:0]);
            check("vec", $sformatf("illegal #%0d", i), 32'(illegal), 32'h0);
        end

        // R10 load address, no write
        issue(enc_i(8'h23, 1, 5, 16'hFFFC), 1'b1);
        check("R10", "load addr", eff_addr, 32'h0000_1231);
        check("R10", "load wb_en", 32'(wb_en), 32'h0);
        check("R10", "load wb_idx", 32'(wb_idx), 32'd5);
        check("R10", "load illegal", 32'(illegal), 32'h0);
        // R10 store address, no write
        issue(enc_i(8'h2B, 2, 3, 16'h0008), 1'b1);
        check("R10", "store addr", eff_addr, 32'h8000_0008);
        check("R10", "store wb_en", 32'(wb_en), 32'h0);
        read_reg(5, "R10", 32'h0000_8001);

        // R11 unknown opcode
        issue(enc_i(8'h3F, 1, 6, 16'h0001), 1'b1);
        check("R11", "bad op flag", 32'(illegal), 32'h1);
        check("R11", "bad op wb_en", 32'(wb_en), 32'h0);
        // R11 unknown funct aimed at r6
        issue(enc_r(1, 1, 6, 0, 8'h21), 1'b1);
        check("R11", "bad funct flag", 32'(illegal), 32'h1);
        check("R11", "bad funct wb_en", 32'(wb_en), 32'h0);
        read_reg(6, "R11", 32'h0000_1233);

        // R12 invalid instruction does nothing
        issue(enc_r(1, 1, 6, 0, 8'h20), 1'b0);
        check("R12", "wb_en", 32'(wb_en), 32'h0);
        check("R12", "illegal", 32'(illegal), 32'h0);
        read_reg(6, "R12", 32'h0000_1233);

        // R1 reset mid-run clears state
        @(negedge clk);
        instr_valid = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        read_reg(1, "R1", 32'h0);
        read_reg(2, "R1", 32'h0);

        @(negedge clk);
        instr_valid = 1'b0;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule